// File: doc/BRIEF.md
# Multi-Mode Audio FIFO Address Generator

This block generates the RAM addresses for an audio DMA path. Converter samples arrive on a valid strobe with a channel tag, and each one is written into an input FIFO region of shared RAM. The position of each sample depends on the selected channel arrangement. On the output side, each read request takes the next sample from an output FIFO region. One clock later it returns that sample toward the playback stage, or returns a zero while the mute input was high.

There are four channel arrangements. Single-channel packs samples back to back. Stereo-in/mono-out interleaves two input channels and reads one output channel from the lower half. Split-halves gives each input channel its own half and also reads from the lower half. Full stereo interleaves both directions.

The input FIFO has two views of its contents. The rotating view publishes the start address of the newest complete block, and that address moves as blocks land. The pinned view translates an offset so that offset 0 always lands on the newest complete block. A one-cycle pulse marks each completed input block.

Top module: `audio_fifo_addr_gen`

## Requirements
- R1: Mode 0 (single-channel): the n-th write after a pointer clear goes to address n mod DEPTH, and the channel tag is ignored.
- R2: Modes 1 and 3 (interleaved input): the k-th sample of channel c goes to address (2k + c) mod DEPTH, so channel 0 lands on even addresses.
- R3: Mode 2 (split halves): the k-th sample of channel c goes to address c*DEPTH/2 + (k mod DEPTH/2).
- R4: Output addresses follow the mode. Mode 0 reads n mod DEPTH. Modes 1 and 2 read n mod DEPTH/2 in the lower half and ignore the output channel tag. Mode 3 reads (2k + c) mod DEPTH for the k-th read of channel c.
- R5: `blk_rdy` is high for exactly one cycle, in the cycle after the write that completes a block. A block is BLOCK_LEN words in mode 0 and 2*BLOCK_LEN words in the other modes.
- R6: `blk_base` (rotating view) gives the start address of the newest complete block. For modes 1 and 3 this is the frame index times 2. For mode 2 it is the offset within a half.
- R7: `view_addr` (pinned view) equals (`view_off` + `blk_base`) mod DEPTH. In mode 2 the top bit of `view_off` selects the half, and the sum wraps within that half.
- R8: `out_valid` rises in the cycle after an `out_req`, and `out_data` then carries the RAM word read at the requested address. The RAM read latency is one cycle.
- R9: If `mute_i` was high in the request cycle, the returned `out_data` is zero.
- R10: A change of `mode_i` takes effect only in a cycle with neither `in_valid` nor `out_req`. Taking effect clears every read and write pointer, the block count and `blk_base`.
- R11: After reset, the mode is 0, all pointers are zero, and `blk_rdy` and `out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Requested channel arrangement (0..3) |
| mute_i | input | 1 | Low-battery mute; zeroes returned samples |
| in_valid | input | 1 | Input sample strobe |
| in_chan | input | 1 | Channel tag of the input sample |
| in_data | input | DATA_W | Input sample |
| out_req | input | 1 | Output sample request |
| out_chan | input | 1 | Channel tag of the output request |
| ram_we | output | 1 | RAM write enable |
| ram_waddr | output | log2(DEPTH) | RAM write address in the input region |
| ram_wdata | output | DATA_W | RAM write data |
| ram_re | output | 1 | RAM read enable |
| ram_raddr | output | log2(DEPTH) | RAM read address in the output region |
| ram_rdata | input | DATA_W | RAM read data, one cycle after `ram_re` |
| out_valid | output | 1 | Returned sample valid |
| out_data | output | DATA_W | Returned sample, or zero when muted |
| blk_rdy | output | 1 | One-cycle pulse per completed input block |
| blk_base | output | log2(DEPTH) | Rotating-view base of the newest block |
| view_off | input | log2(DEPTH) | Pinned-view offset |
| view_addr | output | log2(DEPTH) | Pinned-view physical address |

## Verification
The hardest situation to reach is a mode request that arrives while traffic is still flowing. The change must wait, and the write in that same cycle must still use the old arrangement. The stimulus drives a new `mode_i` in the same cycle as a write with channel tag 1. It expects the single-channel address, and then expects a cleared interleaved address after one idle cycle. Wrap-around of the rotating base and of the pinned view is reached by streaming whole FIFOs of ramp data in each mode. The mixed mode's per-half wrap uses an offset whose sum overflows the half.

// File: rtl/afg_pkg.sv
package afg_pkg;
    typedef enum logic [1:0] {
        MODE_MONO        = 2'd0,
        MODE_STEREO_IN   = 2'd1,
        MODE_MIXED       = 2'd2,
        MODE_STEREO_FULL = 2'd3
    } audio_mode_e;
endpackage

// File: rtl/afg_mode_ctl.sv
module afg_mode_ctl
    import afg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  audio_mode_e mode_req,
    input  logic        in_valid,
    input  logic        out_req,
    output audio_mode_e mode_q,
    output logic        clr
);
    audio_mode_e mode_d;

    always_comb begin
        mode_d = mode_q;
        clr    = 1'b0;
        if ((mode_req != mode_q) && !in_valid && !out_req) begin
            mode_d = mode_req;
            clr    = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_MONO;
        else        mode_q <= mode_d;
    end

    // R10: the active arrangement moves only across an idle cycle
    a_r10_idle_change: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_q) |-> $past(!in_valid && !out_req));
endmodule

// File: rtl/afg_in_addr.sv
module afg_in_addr
    import afg_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int BLOCK_LEN = 4,
    localparam int AW       = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  audio_mode_e    mode,
    input  logic           clr,
    input  logic           wr_valid,
    input  logic           wr_chan,
    input  logic [AW-1:0]  view_off,
    output logic [AW-1:0]  wr_addr,
    output logic           blk_rdy,
    output logic [AW-1:0]  blk_base,
    output logic [AW-1:0]  view_addr
);
    localparam int CW                = $clog2(2 * BLOCK_LEN) + 1;
    localparam logic [AW-1:0] FULL_M = AW'(DEPTH - 1);
    localparam logic [AW-1:0] HALF_M = AW'(DEPTH / 2 - 1);
    localparam logic [AW-1:0] BL_A   = AW'(BLOCK_LEN);

    typedef struct packed {
        logic [AW-1:0] idx0;
        logic [AW-1:0] idx1;
        logic [CW-1:0] cnt;
        logic [AW-1:0] base;
        logic          rdy;
    } in_st_t;

    in_st_t        s_d, s_q;
    logic          ch;
    logic [AW-1:0] cur, nxt, mask, start;
    logic [CW-1:0] words;

    always_comb begin
        s_d       = s_q;
        s_d.rdy   = 1'b0;
        ch        = (mode == MODE_MONO) ? 1'b0 : wr_chan;
        cur       = ch ? s_q.idx1 : s_q.idx0;
        mask      = (mode == MODE_MONO) ? FULL_M : HALF_M;
        nxt       = (cur + 1'b1) & mask;
        words     = (mode == MODE_MONO) ? CW'(BLOCK_LEN) : CW'(2 * BLOCK_LEN);
        start     = '0;

        case (mode)
            MODE_MONO:  wr_addr = cur;
            MODE_MIXED: wr_addr = {ch, cur[AW-2:0]};
            default:    wr_addr = {cur[AW-2:0], ch};
        endcase

        if (clr) begin
            s_d = '0;
        end else if (wr_valid) begin
            if (ch) s_d.idx1 = nxt;
            else    s_d.idx0 = nxt;
            if (s_q.cnt + 1'b1 == words) begin
                s_d.cnt = '0;
                s_d.rdy = 1'b1;
                start   = (s_d.idx0 - BL_A) & mask;
                if (mode == MODE_MONO || mode == MODE_MIXED) s_d.base = start;
                else                                         s_d.base = {start[AW-2:0], 1'b0};
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end

        if (mode == MODE_MIXED) view_addr = {view_off[AW-1], view_off[AW-2:0] + s_q.base[AW-2:0]};
        else                    view_addr = view_off + s_q.base;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign blk_rdy  = s_q.rdy;
    assign blk_base = s_q.base;

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        blk_rdy |=> !blk_rdy);
    a_r1_mono_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && mode == MODE_MONO && $past(wr_valid) && $past(mode) == MODE_MONO)
        |-> wr_addr == AW'($past(wr_addr) + 1'b1));
    a_r2_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && (mode == MODE_STEREO_IN || mode == MODE_STEREO_FULL))
        |-> wr_addr[0] == wr_chan);
    a_r3_half_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && mode == MODE_MIXED) |-> wr_addr[AW-1] == wr_chan);
    a_r10_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (blk_base == '0 && !blk_rdy));
    a_r6_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!blk_rdy && !$past(clr)) |-> $stable(blk_base));
endmodule

// File: rtl/afg_out_addr.sv
module afg_out_addr
    import afg_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int DATA_W   = 16,
    localparam int AW      = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  audio_mode_e       mode,
    input  logic              clr,
    input  logic              rd_req,
    input  logic              rd_chan,
    input  logic              mute,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [AW-1:0]     rd_addr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [AW-1:0] FULL_M = AW'(DEPTH - 1);
    localparam logic [AW-1:0] HALF_M = AW'(DEPTH / 2 - 1);

    typedef struct packed {
        logic [AW-1:0] idx0;
        logic [AW-1:0] idx1;
        logic          vld;
        logic          mute;
    } out_st_t;

    out_st_t       s_d, s_q;
    logic          ch;
    logic [AW-1:0] cur, nxt, mask;

    always_comb begin
        s_d      = s_q;
        s_d.vld  = rd_req;
        s_d.mute = mute;
        ch       = (mode == MODE_STEREO_FULL) ? rd_chan : 1'b0;
        cur      = ch ? s_q.idx1 : s_q.idx0;
        mask     = (mode == MODE_MONO) ? FULL_M : HALF_M;
        nxt      = (cur + 1'b1) & mask;

        case (mode)
            MODE_MONO:        rd_addr = cur;
            MODE_STEREO_FULL: rd_addr = {cur[AW-2:0], ch};
            default:          rd_addr = {1'b0, cur[AW-2:0]};
        endcase

        if (clr) begin
            s_d.idx0 = '0;
            s_d.idx1 = '0;
        end else if (rd_req) begin
            if (ch) s_d.idx1 = nxt;
            else    s_d.idx0 = nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_valid = s_q.vld;
    assign rd_data  = (s_q.vld && !s_q.mute) ? ram_rdata : '0;

    a_r4_lower_half: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && (mode == MODE_STEREO_IN || mode == MODE_MIXED)) |-> rd_addr[AW-1] == 1'b0);
    a_r8_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);
endmodule

// File: rtl/audio_fifo_addr_gen.sv
module audio_fifo_addr_gen
    import afg_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int BLOCK_LEN = 4,
    parameter int DATA_W    = 16,
    localparam int AW       = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              mute_i,
    input  logic              in_valid,
    input  logic              in_chan,
    input  logic [DATA_W-1:0] in_data,
    input  logic              out_req,
    input  logic              out_chan,
    output logic              ram_we,
    output logic [AW-1:0]     ram_waddr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              ram_re,
    output logic [AW-1:0]     ram_raddr,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              blk_rdy,
    output logic [AW-1:0]     blk_base,
    input  logic [AW-1:0]     view_off,
    output logic [AW-1:0]     view_addr
);
    audio_mode_e mode_req, mode_q;
    logic        clr;

    assign mode_req  = audio_mode_e'(mode_i);
    assign ram_we    = in_valid;
    assign ram_wdata = in_data;
    assign ram_re    = out_req;

    afg_mode_ctl u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_req (mode_req),
        .in_valid (in_valid),
        .out_req  (out_req),
        .mode_q   (mode_q),
        .clr      (clr)
    );

    afg_in_addr #(.DEPTH(DEPTH), .BLOCK_LEN(BLOCK_LEN)) u_in (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_q),
        .clr       (clr),
        .wr_valid  (in_valid),
        .wr_chan   (in_chan),
        .view_off  (view_off),
        .wr_addr   (ram_waddr),
        .blk_rdy   (blk_rdy),
        .blk_base  (blk_base),
        .view_addr (view_addr)
    );

    afg_out_addr #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_q),
        .clr       (clr),
        .rd_req    (out_req),
        .rd_chan   (out_chan),
        .mute      (mute_i),
        .ram_rdata (ram_rdata),
        .rd_addr   (ram_raddr),
        .rd_valid  (out_valid),
        .rd_data   (out_data)
    );

    a_r9_mute_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(mute_i)) |-> out_data == '0);
    a_r11_params: assert property (@(posedge clk)
        (BLOCK_LEN >= 2) && (2 * BLOCK_LEN <= DEPTH));
endmodule

// File: tb/audio_fifo_addr_gen_tb.sv
module audio_fifo_addr_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam int BL    = 4;
    localparam int DW    = 16;
    localparam int AW    = 4;
    localparam int NTBL  = 25;

    // entry: [7:6] mode, [5] channel, [4:1] expected write address, [0] expected block pulse
    localparam logic [7:0] TBL [NTBL] = '{
        {2'd0,1'b1,4'd0,1'b0}, {2'd0,1'b0,4'd1,1'b0}, {2'd0,1'b1,4'd2,1'b0},
        {2'd0,1'b0,4'd3,1'b1}, {2'd0,1'b1,4'd4,1'b0}, {2'd0,1'b1,4'd5,1'b0},
        {2'd1,1'b0,4'd0,1'b0}, {2'd1,1'b1,4'd1,1'b0}, {2'd1,1'b0,4'd2,1'b0},
        {2'd1,1'b1,4'd3,1'b0}, {2'd1,1'b0,4'd4,1'b0}, {2'd1,1'b1,4'd5,1'b0},
        {2'd1,1'b0,4'd6,1'b0}, {2'd1,1'b1,4'd7,1'b1},
        {2'd2,1'b0,4'd0,1'b0}, {2'd2,1'b1,4'd8,1'b0}, {2'd2,1'b1,4'd9,1'b0},
        {2'd2,1'b0,4'd1,1'b0}, {2'd2,1'b0,4'd2,1'b0}, {2'd2,1'b1,4'd10,1'b0},
        {2'd2,1'b0,4'd3,1'b0}, {2'd2,1'b1,4'd11,1'b1},
        {2'd3,1'b0,4'd0,1'b0}, {2'd3,1'b1,4'd1,1'b0}, {2'd3,1'b0,4'd2,1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode_i = 2'd0;
    logic          mute_i = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_chan = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          out_req = 1'b0;
    logic          out_chan = 1'b0;
    logic          ram_we, ram_re, out_valid, blk_rdy;
    logic [AW-1:0] ram_waddr, ram_raddr, blk_base, view_addr;
    logic [AW-1:0] view_off = '0;
    logic [DW-1:0] ram_wdata, out_data;
    logic [DW-1:0] ram_rdata = '0;
    logic [DW-1:0] mem [DEPTH];

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        if (ram_we) mem[ram_waddr] <= ram_wdata;
        if (ram_re) ram_rdata <= mem[ram_raddr];
    end

    audio_fifo_addr_gen #(.DEPTH(DEPTH), .BLOCK_LEN(BL), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .mute_i(mute_i),
        .in_valid(in_valid), .in_chan(in_chan), .in_data(in_data),
        .out_req(out_req), .out_chan(out_chan),
        .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
        .ram_re(ram_re), .ram_raddr(ram_raddr), .ram_rdata(ram_rdata),
        .out_valid(out_valid), .out_data(out_data), .blk_rdy(blk_rdy),
        .blk_base(blk_base), .view_off(view_off), .view_addr(view_addr)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic set_mode(input logic [1:0] m);
        mode_i   = m;
        in_valid = 1'b0;
        out_req  = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_write(input logic ch, input logic [DW-1:0] d, input int exp_addr,
                            input int exp_rdy, input string tag);
        in_valid = 1'b1;
        in_chan  = ch;
        in_data  = d;
        #1;
        chk(tag, "write address", int'(ram_waddr), exp_addr);
        @(negedge clk);
        chk("R5", "block pulse", int'(blk_rdy), exp_rdy);
        in_valid = 1'b0;
    endtask

    task automatic do_read(input logic ch, input logic m, input int exp_addr,
                           input int exp_data, input string tag);
        out_req  = 1'b1;
        out_chan = ch;
        mute_i   = m;
        #1;
        chk(tag, "read address", int'(ram_raddr), exp_addr);
        @(negedge clk);
        chk("R8", "out_valid", int'(out_valid), 1);
        chk(m ? "R9" : "R8", "out_data", int'(out_data), exp_data);
        out_req = 1'b0;
        mute_i  = 1'b0;
    endtask

    function automatic int mem_after_c(input int a);
        if (a == 0) return 32'h200;
        if (a == 1) return 32'h201;
        return 32'h100 + a;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog all-requirements actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [1:0] cur_mode;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        view_off = 4'd5;
        #1;
        // R11 reset state
        chk("R11", "blk_rdy", int'(blk_rdy), 0);
        chk("R11", "out_valid", int'(out_valid), 0);
        chk("R11", "blk_base", int'(blk_base), 0);
        chk("R11", "out_data", int'(out_data), 0);
        chk("R7", "view after reset", int'(view_addr), 5);
        @(negedge clk);

        // table walk: R1 mono, R2 interleaved, R3 halves, R5 pulses
        cur_mode = 2'd0;
        for (int i = 0; i < NTBL; i++) begin
            if (TBL[i][7:6] != cur_mode) begin
                cur_mode = TBL[i][7:6];
                set_mode(cur_mode);
            end
            do_write(TBL[i][5], DW'(16'h50 + i), int'(TBL[i][4:1]), int'(TBL[i][0]),
                     (cur_mode == 2'd0) ? "R1" : (cur_mode == 2'd2) ? "R3" : "R2");
        end

        // R6/R7 single-channel ramp over a whole FIFO
        set_mode(2'd0);
        for (int i = 0; i < DEPTH; i++) begin
            do_write(1'b0, DW'(16'h100 + i), i, (i % BL == BL - 1) ? 1 : 0, "R1");
            if (i == 3) chk("R6", "base block 0", int'(blk_base), 0);
            if (i == 7) begin
                chk("R6", "base block 1", int'(blk_base), 4);
                view_off = 4'd1; #1;
                chk("R7", "pinned view", int'(view_addr), 5);
            end
        end
        chk("R6", "base block 3", int'(blk_base), 12);
        view_off = 4'd6; #1;
        chk("R7", "pinned view wrap", int'(view_addr), 2);

        // R4/R8/R9 single-channel reads
        for (int i = 0; i < 4; i++) do_read(1'b1, 1'b0, i, 16'h100 + i, "R4");
        do_read(1'b0, 1'b1, 4, 0, "R4");
        do_read(1'b0, 1'b0, 5, 16'h105, "R4");
        @(negedge clk);
        chk("R8", "idle out_valid", int'(out_valid), 0);

        // R10 mode request during a write is deferred
        mode_i = 2'd1;
        do_write(1'b1, 16'h200, 0, 0, "R10");
        @(negedge clk);
        chk("R10", "base cleared", int'(blk_base), 0);
        do_write(1'b1, 16'h201, 1, 0, "R10");

        // R4 lower-half reads with wrap, channel tag ignored
        for (int i = 0; i <= 8; i++) do_read(1'b1, 1'b0, i % 8, mem_after_c(i % 8), "R4");

        // R4 full stereo reads
        set_mode(2'd3);
        do_read(1'b1, 1'b0, 1, 16'h201, "R4");
        do_read(1'b0, 1'b0, 0, 16'h200, "R4");
        do_read(1'b1, 1'b0, 3, 16'h103, "R4");

        // R3/R6/R7 split halves
        set_mode(2'd2);
        for (int i = 0; i < 16; i++) begin
            int exp_a;
            exp_a = (i % 2) * 8 + i / 2;
            do_write(1'(i % 2), DW'(16'h300 + exp_a), exp_a, (i % 8 == 7) ? 1 : 0, "R3");
            if (i == 7) chk("R6", "halves base 0", int'(blk_base), 0);
        end
        chk("R6", "halves base 1", int'(blk_base), 4);
        view_off = 4'd13; #1;
        chk("R7", "half wrap view", int'(view_addr), 9);
        do_read(1'b1, 1'b0, 0, 16'h300, "R4");
        do_read(1'b0, 1'b0, 1, 16'h301, "R4");

        // R2/R6/R7 interleaved base
        set_mode(2'd1);
        for (int i = 0; i < 16; i++)
            do_write(1'(i % 2), DW'(i), i, (i % 8 == 7) ? 1 : 0, "R2");
        chk("R6", "interleaved base", int'(blk_base), 8);
        view_off = 4'd10; #1;
        chk("R7", "interleaved view", int'(view_addr), 2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule